// File: doc/BRIEF.md
# Masked Repeating Alarm Controller

This block watches the running clock and calendar digits of a real-time clock and raises an alarm event when they equal a stored alarm value. A 4-bit mask code decides which digits take part in the comparison, so the same stored value can give an event every half second or only once a year. Matching is tested only on the rising edge of a half-second tick, so each qualifying instant gives at most one event, however long the tick input stays high.

Each event produces a one-cycle interrupt pulse and flips a toggle output, which runs at half the alarm rate. An 8-bit repeat count goes down by one on each event. When an event arrives with the count at zero, the enable bit clears itself and the alarm stops. If chime is set, the count wraps from zero to 0xFF and the alarm keeps running. The enable bit and the count can be read back. The stored alarm value can be changed only while the alarm is disabled.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `alarm_sequencer`

## Requirements
- R1: After reset the enable readback is 0, the count readback is 0x00, the interrupt is 0 and the toggle output is 0.
- R2: Time and alarm values are 44 bits wide, packed as {half[43], weekday[42:40], month[39:32], day[31:24], hour[23:16], minute[15:8], second[7:0]}. Minute and second are BCD, with ones in the low nibble. The fields compared for each mask code are:
  - 0: none
  - 1: half
  - 2: half and second ones
  - 3: half and full second
  - 4: adds minute ones
  - 5: adds full minute
  - 6: adds hour
  - 7: adds weekday
  - 8: code 6 fields plus day
  - 9: code 6 fields plus day and month
  - 10 to 15: never match
- R3: A match is tested only in a cycle where tick_half is 1 and was 0 in the previous cycle. Holding tick_half high gives one event.
- R4: An event makes alarm_irq high for exactly one cycle, in the cycle after the clock edge that sampled the tick rise.
- R5: alarm_toggle flips on every event and holds its value otherwise.
- R6: An event with a nonzero count lowers the count by one and leaves the enable bit set.
- R7: An event with the count at 0 and chime off clears the enable bit. Arming with count N therefore gives N+1 events.
- R8: An event with the count at 0 and chime on loads 0xFF into the count and leaves the enable bit set.
- R9: A write to the alarm value is ignored while the enable bit is set.
- R10: A software write to the enable bit or the count in the same cycle as an event takes priority over the hardware update. The event's interrupt still occurs.
- R11: No event occurs while the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_half | input | 1 | Half-second tick; its rising edge is the match instant |
| time_now | input | 44 | Current time digits, packed as in R2 |
| cfg_mask | input | 4 | Mask code (R2) |
| cfg_chime | input | 1 | Indefinite repeat mode |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_val | input | 1 | Enable value to write |
| cfg_cnt_we | input | 1 | Write strobe for the repeat count |
| cfg_cnt_val | input | 8 | Repeat count to write |
| cfg_alm_we | input | 1 | Write strobe for the alarm value |
| cfg_alm_val | input | 44 | Alarm value to write |
| alarm_irq | output | 1 | One-cycle interrupt per event |
| alarm_toggle | output | 1 | Flips on each event |
| en_rb | output | 1 | Enable bit readback |
| cnt_rb | output | 8 | Repeat count readback |

## Verification
A hardware event and a software write to the count or the enable bit can land in the same cycle. In that case the write must win, and the interrupt must still fire. The bench provokes this by raising tick_half in the same cycle as the write strobe, on a matching time. It then samples after the next clock edge and expects the interrupt high, with the written value in the readback, not the decremented one or the cleared one. A second case puts a final-shot event together with a write of 1 to the enable bit.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int TIME_W = 44;
  localparam int MASK_W = 4;

  typedef struct packed {
    logic       half;
    logic [2:0] wday;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  typedef struct packed {
    logic never;
    logic half;
    logic sec_lo;
    logic sec_hi;
    logic min_lo;
    logic min_hi;
    logic hour;
    logic wday;
    logic day;
    logic mon;
  } field_sel_t;

  function automatic field_sel_t decode_mask(input logic [MASK_W-1:0] m);
    field_sel_t s;
    s.never  = (m > 4'd9);
    s.half   = (m >= 4'd1) && (m <= 4'd9);
    s.sec_lo = (m >= 4'd2) && (m <= 4'd9);
    s.sec_hi = (m >= 4'd3) && (m <= 4'd9);
    s.min_lo = (m >= 4'd4) && (m <= 4'd9);
    s.min_hi = (m >= 4'd5) && (m <= 4'd9);
    s.hour   = (m >= 4'd6) && (m <= 4'd9);
    s.wday   = (m == 4'd7);
    s.day    = (m == 4'd8) || (m == 4'd9);
    s.mon    = (m == 4'd9);
    return s;
  endfunction
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] ref_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o
);
  rtc_time_t  a, b;
  field_sel_t sel;
  logic [8:0] ok;

  always_comb begin
    a   = rtc_time_t'(now_i);
    b   = rtc_time_t'(ref_i);
    sel = decode_mask(mask_i);
    ok[0] = !sel.half   || (a.half == b.half);
    ok[1] = !sel.sec_lo || (a.second[3:0] == b.second[3:0]);
    ok[2] = !sel.sec_hi || (a.second[7:4] == b.second[7:4]);
    ok[3] = !sel.min_lo || (a.minute[3:0] == b.minute[3:0]);
    ok[4] = !sel.min_hi || (a.minute[7:4] == b.minute[7:4]);
    ok[5] = !sel.hour   || (a.hour == b.hour);
    ok[6] = !sel.wday   || (a.wday == b.wday);
    ok[7] = !sel.day    || (a.day == b.day);
    ok[8] = !sel.mon    || (a.mon == b.mon);
    hit_o = !sel.never && (&ok);
  end
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic armed_i,
  input  logic hit_i,
  output logic fire_o,
  output logic irq_o,
  output logic toggle_o
);
  logic tick_q;

  assign fire_o = tick_i && !tick_q && armed_i && hit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q   <= 1'b0;
      irq_o    <= 1'b0;
      toggle_o <= 1'b0;
    end else begin
      tick_q <= tick_i;
      irq_o  <= fire_o;
      if (fire_o) toggle_o <= !toggle_o;
    end
  end
endmodule

// File: rtl/alarm_repeat.sv
module alarm_repeat #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             chime_i,
  input  logic             en_we_i,
  input  logic             en_val_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
      cnt_o <= CNT_ZERO;
    end else begin
      if (fire_i) begin
        if (cnt_o == CNT_ZERO) begin
          if (chime_i) cnt_o <= CNT_FULL;
          else         en_o  <= 1'b0;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
      if (en_we_i)  en_o  <= en_val_i;
      if (cnt_we_i) cnt_o <= cnt_val_i;
    end
  end
endmodule

// File: rtl/alarm_sequencer.sv
module alarm_sequencer
  import alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_half,
  input  logic [TIME_W-1:0] time_now,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_chime,
  input  logic              cfg_en_we,
  input  logic              cfg_en_val,
  input  logic              cfg_cnt_we,
  input  logic [CNT_W-1:0]  cfg_cnt_val,
  input  logic              cfg_alm_we,
  input  logic [TIME_W-1:0] cfg_alm_val,
  output logic              alarm_irq,
  output logic              alarm_toggle,
  output logic              en_rb,
  output logic [CNT_W-1:0]  cnt_rb
);
  logic [TIME_W-1:0] alm_q;
  logic              hit;
  logic              fire;

  always_ff @(posedge clk) begin
    if (!rst_n)                    alm_q <= '0;
    else if (cfg_alm_we && !en_rb) alm_q <= cfg_alm_val;
  end

  alarm_match u_match (
    .now_i  (time_now),
    .ref_i  (alm_q),
    .mask_i (cfg_mask),
    .hit_o  (hit)
  );

  alarm_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_half),
    .armed_i  (en_rb),
    .hit_i    (hit),
    .fire_o   (fire),
    .irq_o    (alarm_irq),
    .toggle_o (alarm_toggle)
  );

  alarm_repeat #(.CNT_W(CNT_W)) u_repeat (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .chime_i   (cfg_chime),
    .en_we_i   (cfg_en_we),
    .en_val_i  (cfg_en_val),
    .cnt_we_i  (cfg_cnt_we),
    .cnt_val_i (cfg_cnt_val),
    .en_o      (en_rb),
    .cnt_o     (cnt_rb)
  );
endmodule

// File: rtl/alarm_sequencer_chk.sv
module alarm_sequencer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_half,
  input logic             cfg_chime,
  input logic             cfg_en_we,
  input logic             cfg_cnt_we,
  input logic             alarm_irq,
  input logic             alarm_toggle,
  input logic             en_rb,
  input logic [CNT_W-1:0] cnt_rb
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] FULL = '1;

  a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> ($past(tick_half) && !$past(tick_half, 2)));

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |=> !alarm_irq);

  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (alarm_toggle != $past(alarm_toggle)));

  a_r5_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_irq |-> $stable(alarm_toggle));

  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && $past(cnt_rb) != ZERO && !$past(cfg_cnt_we))
      |-> (cnt_rb == $past(cnt_rb) - 1'b1));

  a_r7_final_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && $past(cnt_rb) == ZERO && !$past(cfg_chime) && !$past(cfg_en_we))
      |-> !en_rb);

  a_r8_chime_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && $past(cnt_rb) == ZERO && $past(cfg_chime)
       && !$past(cfg_cnt_we) && !$past(cfg_en_we))
      |-> (cnt_rb == FULL && en_rb));

  a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_rb) |-> !alarm_irq);
endmodule

bind alarm_sequencer alarm_sequencer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_alarm_sequencer.sv
module tb_alarm_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_half = 1'b0;
  logic [43:0] time_now = '0;
  logic [3:0]  cfg_mask = '0;
  logic        cfg_chime = 1'b0;
  logic        cfg_en_we = 1'b0, cfg_en_val = 1'b0;
  logic        cfg_cnt_we = 1'b0;
  logic [7:0]  cfg_cnt_val = '0;
  logic        cfg_alm_we = 1'b0;
  logic [43:0] cfg_alm_val = '0;
  logic        alarm_irq, alarm_toggle, en_rb;
  logic [7:0]  cnt_rb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  alarm_sequencer dut (.*);

  // alarm value A: half=1 wday=3 mon=06 day=15 hour=13 min=47 sec=29
  localparam logic [43:0] VAL_A = {1'b1, 3'd3, 8'h06, 8'h15, 8'h13, 8'h47, 8'h29};
  localparam logic [43:0] VAL_B = {1'b0, 3'd5, 8'h11, 8'h02, 8'h08, 8'h10, 8'h55};

  // {mask, expected irq, time}
  localparam int NV = 19;
  localparam logic [48:0] VEC [NV] = '{
    {4'd0,  1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1,  1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1,  1'b0, 1'b0, 3'd3, 8'h06, 8'h15, 8'h13, 8'h47, 8'h29},
    {4'd2,  1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h39},
    {4'd2,  1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h28},
    {4'd3,  1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h29},
    {4'd4,  1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h57, 8'h29},
    {4'd4,  1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h46, 8'h29},
    {4'd5,  1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h47, 8'h29},
    {4'd6,  1'b1, 1'b1, 3'd0, 8'h01, 8'h01, 8'h13, 8'h47, 8'h29},
    {4'd6,  1'b0, 1'b1, 3'd3, 8'h06, 8'h15, 8'h12, 8'h47, 8'h29},
    {4'd7,  1'b1, 1'b1, 3'd3, 8'h01, 8'h01, 8'h13, 8'h47, 8'h29},
    {4'd7,  1'b0, 1'b1, 3'd2, 8'h06, 8'h15, 8'h13, 8'h47, 8'h29},
    {4'd8,  1'b1, 1'b1, 3'd0, 8'h01, 8'h15, 8'h13, 8'h47, 8'h29},
    {4'd8,  1'b0, 1'b1, 3'd3, 8'h06, 8'h16, 8'h13, 8'h47, 8'h29},
    {4'd9,  1'b1, 1'b1, 3'd0, 8'h06, 8'h15, 8'h13, 8'h47, 8'h29},
    {4'd9,  1'b0, 1'b1, 3'd3, 8'h07, 8'h15, 8'h13, 8'h47, 8'h29},
    {4'd10, 1'b0, 1'b1, 3'd3, 8'h06, 8'h15, 8'h13, 8'h47, 8'h29},
    {4'd15, 1'b0, 1'b1, 3'd3, 8'h06, 8'h15, 8'h13, 8'h47, 8'h29}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); cfg_en_we = 1'b1; cfg_en_val = v;
    @(negedge clk); cfg_en_we = 1'b0;
  endtask

  task automatic set_cnt(input logic [7:0] v);
    @(negedge clk); cfg_cnt_we = 1'b1; cfg_cnt_val = v;
    @(negedge clk); cfg_cnt_we = 1'b0;
  endtask

  task automatic set_alm(input logic [43:0] v);
    @(negedge clk); cfg_alm_we = 1'b1; cfg_alm_val = v;
    @(negedge clk); cfg_alm_we = 1'b0;
  endtask

  // one-cycle tick; returns at the negedge after the edge that registers the event
  task automatic pulse_tick();
    @(negedge clk); tick_half = 1'b1;
    @(negedge clk); tick_half = 1'b0;
  endtask

  task automatic arm(input logic [3:0] m, input logic ch, input logic [7:0] c);
    set_en(1'b0);
    set_alm(VAL_A);
    cfg_mask = m; cfg_chime = ch;
    set_cnt(c);
    set_en(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int irqs;
    logic tg;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(en_rb == 1'b0 && cnt_rb == 8'h00 && !alarm_irq && !alarm_toggle,
          "R1 reset", {en_rb, cnt_rb, alarm_irq, alarm_toggle}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 mask table
    foreach (VEC[i]) begin
      arm(VEC[i][48:45], 1'b1, 8'hFF);
      time_now = VEC[i][43:0];
      pulse_tick();
      check(alarm_irq == VEC[i][44], $sformatf("R2 mask %0d vec %0d", VEC[i][48:45], i),
            alarm_irq, VEC[i][44]);
    end

    // R3 held tick gives one event; R4 pulse width
    arm(4'd0, 1'b1, 8'hFF);
    irqs = 0;
    @(negedge clk); tick_half = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (alarm_irq) irqs++;
    end
    tick_half = 1'b0;
    repeat (2) begin @(negedge clk); if (alarm_irq) irqs++; end
    check(irqs == 1, "R3 held tick single event / R4 one-cycle irq", irqs, 1);

    // R5 toggle flips per event; R6 decrement; R7 final shot
    arm(4'd0, 1'b0, 8'd2);
    tg = alarm_toggle;
    pulse_tick();
    check(alarm_toggle == !tg, "R5 toggle flip", alarm_toggle, !tg);
    check(cnt_rb == 8'd1 && en_rb, "R6 decrement 2->1", {en_rb, cnt_rb}, 9'h101);
    @(negedge clk);
    check(!alarm_irq, "R4 irq drops", alarm_irq, 0);
    check(alarm_toggle == !tg, "R5 toggle holds", alarm_toggle, !tg);
    pulse_tick();
    check(cnt_rb == 8'd0 && en_rb, "R6 decrement 1->0", {en_rb, cnt_rb}, 9'h100);
    pulse_tick();
    check(alarm_irq && !en_rb, "R7 final shot clears enable", {alarm_irq, en_rb}, 2'b10);
    pulse_tick();
    check(!alarm_irq, "R11 no event while disabled", alarm_irq, 0);
    check(alarm_toggle == !tg, "R5 three events flip parity", alarm_toggle, !tg);

    // R8 chime wrap
    arm(4'd0, 1'b1, 8'd0);
    pulse_tick();
    check(alarm_irq && en_rb && cnt_rb == 8'hFF, "R8 chime wrap", {alarm_irq, en_rb, cnt_rb}, 10'h3FF);

    // R9 alarm value write ignored while enabled
    arm(4'd9, 1'b1, 8'hFF);
    set_alm(VAL_B);
    time_now = VAL_A;
    pulse_tick();
    check(alarm_irq == 1'b1, "R9 old value still matches", alarm_irq, 1);
    time_now = VAL_B;
    pulse_tick();
    check(alarm_irq == 1'b0, "R9 new value not taken", alarm_irq, 0);

    // R10 count write wins over decrement
    arm(4'd0, 1'b0, 8'd5);
    @(negedge clk); tick_half = 1'b1; cfg_cnt_we = 1'b1; cfg_cnt_val = 8'h40;
    @(negedge clk); tick_half = 1'b0; cfg_cnt_we = 1'b0;
    check(alarm_irq && cnt_rb == 8'h40, "R10 count write wins", {alarm_irq, cnt_rb}, 9'h140);

    // R10 enable write wins over final-shot clear
    arm(4'd0, 1'b0, 8'd0);
    @(negedge clk); tick_half = 1'b1; cfg_en_we = 1'b1; cfg_en_val = 1'b1;
    @(negedge clk); tick_half = 1'b0; cfg_en_we = 1'b0;
    check(alarm_irq && en_rb, "R10 enable write wins", {alarm_irq, en_rb}, 2'b11);

    // R10 disable write during an event with count left
    arm(4'd0, 1'b0, 8'd3);
    @(negedge clk); tick_half = 1'b1; cfg_en_we = 1'b1; cfg_en_val = 1'b0;
    @(negedge clk); tick_half = 1'b0; cfg_en_we = 1'b0;
    check(alarm_irq && !en_rb && cnt_rb == 8'd2, "R10 disable write wins",
          {alarm_irq, en_rb, cnt_rb}, 10'h202);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule